// File: doc/BRIEF.md
# Shared-Memory Network Interrupt Qualifier

This block sits between the receiver of a ring network that mirrors a shared memory, the local write port of that memory, and the host. Every write that arrives from the network is checked against a small per-word control table and a set of global enables. The block then decides three things:

- whether the write goes into local memory at all;
- whether it also raises an interrupt;
- if so, whether its word address is queued in an address FIFO for the host.

The host reads the queue one address at a time. A level output tells it that at least one address is waiting.

On the transmit side, every host write that leaves for the network is given an interrupt tag. The tag is set when the target word is marked for outgoing interrupts and network interrupts are enabled globally.

Two receive modes are supported. In the selected mode, only words marked in the control table raise interrupts. In the forced mode, every network write raises one. Writes that come back to the node that sent them follow their own rules: the node's own-write enable decides whether such a write is stored, and its own-interrupt enable decides whether it may interrupt.

Top module: `netirq_qualifier`

## Requirements
- R1: In selected mode (cfg_force_all=0), a foreign message (rx_native=0) raises an interrupt when rx_irq_flag, control bit 0 of its word and cfg_match_en are all 1. An interrupting message is written to memory, and its address is pushed into the FIFO.
- R2: A foreign message that does not qualify is still written to memory, but its address is not pushed.
- R3: When the FIFO already holds FIFO_DEPTH addresses, a qualifying address is dropped and irq_overflow is set. irq_overflow stays set until a cycle with irq_ovf_clear=1 in which no new drop occurs. The FIFO never holds more than FIFO_DEPTH entries.
- R4: A native message (rx_native=1) that arrives while cfg_own_write_en=0 produces no memory write and no push.
- R5: A native message that arrives while cfg_own_write_en=1 is written to memory. Its address is pushed only when cfg_own_irq_en=1 and the message qualifies under the rule of the active mode (R1 or R6).
- R6: In forced mode (cfg_force_all=1), a message qualifies whenever cfg_match_en=1, whatever its rx_irq_flag and its control bit 0.
- R7: A host write (hw_valid) is forwarded on tx_valid/tx_addr/tx_data two rising edges later. tx_irq is 1 exactly when control bit 1 of the target word and cfg_net_irq_en were both 1.
- R8: irq_pending is 1 while the FIFO is non-empty. irq_head shows the oldest address. Each irq_pop removes one address in arrival order, and an irq_pop on an empty FIFO has no effect.
- R9: The memory write (mem_wr_en with mem_wr_addr/mem_wr_data) is a one-cycle pulse on the second rising edge after rx_valid is sampled. A push becomes visible on irq_pending/irq_head at that same edge.
- R10: A control-table write (aux_wr_en, aux_wr_bits: bit 0 for receive, bit 1 for transmit) affects messages sampled on later edges. A message sampled on the same edge as the table write still sees the old bits.
- R11: After reset, mem_wr_en, tx_valid, irq_pending and irq_overflow are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_match_en | input | 1 | Global receive interrupt match enable |
| cfg_net_irq_en | input | 1 | Global outgoing interrupt enable |
| cfg_own_write_en | input | 1 | Accept writes that return to the origin node |
| cfg_own_irq_en | input | 1 | Allow self-interrupts |
| cfg_force_all | input | 1 | Forced mode: every network write qualifies |
| aux_wr_en | input | 1 | Control-table write strobe |
| aux_wr_addr | input | ADDR_W | Control-table word address |
| aux_wr_bits | input | 2 | Bit 0 receive enable, bit 1 transmit enable |
| rx_valid | input | 1 | Received message valid |
| rx_addr | input | ADDR_W | Received word address |
| rx_data | input | DATA_W | Received data |
| rx_irq_flag | input | 1 | Message carries the interrupt tag |
| rx_native | input | 1 | Message originated at this node |
| hw_valid | input | 1 | Host write to shared memory |
| hw_addr | input | ADDR_W | Host write address |
| hw_data | input | DATA_W | Host write data |
| mem_wr_en | output | 1 | Shared-memory write strobe |
| mem_wr_addr | output | ADDR_W | Shared-memory write address |
| mem_wr_data | output | DATA_W | Shared-memory write data |
| tx_valid | output | 1 | Outgoing message valid |
| tx_addr | output | ADDR_W | Outgoing address |
| tx_data | output | DATA_W | Outgoing data |
| tx_irq | output | 1 | Outgoing message tagged as interrupt |
| irq_pop | input | 1 | Host reads one queued address |
| irq_head | output | ADDR_W | Oldest queued address |
| irq_pending | output | 1 | Interrupt line, FIFO non-empty |
| irq_ovf_clear | input | 1 | Write-one-to-clear for irq_overflow |
| irq_overflow | output | 1 | Sticky drop indicator |

## Verification
The bench targets the gates that are easy to swap or drop:

- A native message with the own-write enable clear must leave memory untouched. A design that only masked the interrupt would still show a write.
- A foreign message must be stored even when it does not qualify. Tying the write to the push would lose that data.
- Forced mode is run with the interrupt tag and the receive bit both clear. A design that kept those gates would queue nothing.
- The bench fills the FIFO past its depth. A design with an off-by-one depth, or one that overwrote old entries, would queue the wrong addresses or fail to set the overflow flag.
- A table write is issued on the same edge as a message that reads the same word. This exposes a table that forwards new bits early.

// File: rtl/netirq_pkg.sv
package netirq_pkg;
  typedef struct packed {
    logic rx_en;
    logic tx_en;
  } aux_bits_t;

  function automatic aux_bits_t to_aux(input logic [1:0] raw);
    aux_bits_t a;
    a.rx_en = raw[0];
    a.tx_en = raw[1];
    return a;
  endfunction
endpackage

// File: rtl/aux_ctl_ram.sv
module aux_ctl_ram #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        wr_bits,
  input  logic [ADDR_W-1:0] rd_a_addr,
  output logic [1:0]        rd_a_bits,
  input  logic [ADDR_W-1:0] rd_b_addr,
  output logic [1:0]        rd_b_bits
);
  localparam int WORDS = 1 << ADDR_W;

  logic [1:0] table_q [WORDS];

  // Read-first: both ports return the contents before this edge's write.
  always_ff @(posedge clk) begin
    if (wr_en) table_q[wr_addr] <= wr_bits;
    rd_a_bits <= table_q[rd_a_addr];
    rd_b_bits <= table_q[rd_b_addr];
  end
endmodule

// File: rtl/irq_rules.sv
module irq_rules
  import netirq_pkg::*;
(
  input  logic      msg_native,
  input  logic      msg_flag,
  input  aux_bits_t rx_aux,
  input  aux_bits_t tx_aux,
  input  logic      match_en,
  input  logic      net_irq_en,
  input  logic      own_write_en,
  input  logic      own_irq_en,
  input  logic      force_all,
  output logic      do_write,
  output logic      do_push,
  output logic      tx_mark
);
  logic qualifies;

  always_comb begin
    qualifies = match_en && (force_all || (msg_flag && rx_aux.rx_en));
    do_write  = !msg_native || own_write_en;
    do_push   = do_write && qualifies && (!msg_native || own_irq_en);
    tx_mark   = net_irq_en && tx_aux.tx_en;
  end
endmodule

// File: rtl/addr_fifo.sv
module addr_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  input  logic             ovf_clear,
  output logic [W-1:0]     head,
  output logic             not_empty,
  output logic             ovf,
  output logic [CNT_W-1:0] level
);
  logic [W-1:0]     slot_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             full, push_ok, pop_ok;

  assign full      = (level == CNT_W'(DEPTH));
  assign push_ok   = push && !full;
  assign pop_ok    = pop && (level != '0);
  assign not_empty = (level != '0);
  assign head      = slot_q[rd_ptr];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) slot_q[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      ovf    <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
      if (push && full)   ovf <= 1'b1;
      else if (ovf_clear) ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/netirq_qualifier.sv
module netirq_qualifier
  import netirq_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 16,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_match_en,
  input  logic              cfg_net_irq_en,
  input  logic              cfg_own_write_en,
  input  logic              cfg_own_irq_en,
  input  logic              cfg_force_all,
  input  logic              aux_wr_en,
  input  logic [ADDR_W-1:0] aux_wr_addr,
  input  logic [1:0]        aux_wr_bits,
  input  logic              rx_valid,
  input  logic [ADDR_W-1:0] rx_addr,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_irq_flag,
  input  logic              rx_native,
  input  logic              hw_valid,
  input  logic [ADDR_W-1:0] hw_addr,
  input  logic [DATA_W-1:0] hw_data,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  output logic              tx_valid,
  output logic [ADDR_W-1:0] tx_addr,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_irq,
  input  logic              irq_pop,
  output logic [ADDR_W-1:0] irq_head,
  output logic              irq_pending,
  input  logic              irq_ovf_clear,
  output logic              irq_overflow
);
  // Stage 1: message capture alongside the synchronous table read.
  logic              s1_valid, s1_flag, s1_native;
  logic [ADDR_W-1:0] s1_addr;
  logic [DATA_W-1:0] s1_data;
  logic              h1_valid;
  logic [ADDR_W-1:0] h1_addr;
  logic [DATA_W-1:0] h1_data;
  logic [1:0]        rx_bits_raw, tx_bits_raw;
  logic              do_write, do_push, tx_mark;
  logic [CNT_W-1:0]  lvl_cnt;

  aux_ctl_ram #(.ADDR_W(ADDR_W)) aux_i (
    .clk(clk), .wr_en(aux_wr_en), .wr_addr(aux_wr_addr), .wr_bits(aux_wr_bits),
    .rd_a_addr(rx_addr), .rd_a_bits(rx_bits_raw),
    .rd_b_addr(hw_addr), .rd_b_bits(tx_bits_raw)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      h1_valid <= 1'b0;
    end else begin
      s1_valid <= rx_valid;
      h1_valid <= hw_valid;
    end
    s1_addr   <= rx_addr;
    s1_data   <= rx_data;
    s1_flag   <= rx_irq_flag;
    s1_native <= rx_native;
    h1_addr   <= hw_addr;
    h1_data   <= hw_data;
  end

  irq_rules rules_i (
    .msg_native(s1_native), .msg_flag(s1_flag),
    .rx_aux(to_aux(rx_bits_raw)), .tx_aux(to_aux(tx_bits_raw)),
    .match_en(cfg_match_en), .net_irq_en(cfg_net_irq_en),
    .own_write_en(cfg_own_write_en), .own_irq_en(cfg_own_irq_en),
    .force_all(cfg_force_all),
    .do_write(do_write), .do_push(do_push), .tx_mark(tx_mark)
  );

  // Stage 2: registered memory and network outputs.
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_wr_en <= 1'b0;
      tx_valid  <= 1'b0;
      tx_irq    <= 1'b0;
    end else begin
      mem_wr_en <= s1_valid && do_write;
      tx_valid  <= h1_valid;
      tx_irq    <= h1_valid && tx_mark;
    end
    mem_wr_addr <= s1_addr;
    mem_wr_data <= s1_data;
    tx_addr     <= h1_addr;
    tx_data     <= h1_data;
  end

  addr_fifo #(.W(ADDR_W), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk(clk), .rst(rst),
    .push(s1_valid && do_push), .push_data(s1_addr),
    .pop(irq_pop), .ovf_clear(irq_ovf_clear),
    .head(irq_head), .not_empty(irq_pending), .ovf(irq_overflow),
    .level(lvl_cnt)
  );
endmodule

// File: rtl/netirq_qualifier_chk.sv
module netirq_qualifier_chk #(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             rx_valid,
  input logic             rx_native,
  input logic             cfg_own_write_en,
  input logic             mem_wr_en,
  input logic             tx_valid,
  input logic             tx_irq,
  input logic             irq_pending,
  input logic             irq_overflow,
  input logic [CNT_W-1:0] lvl_cnt
);
  assert_mem_wr_latency_R9: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> $past(rx_valid, 2));

  assert_native_discard_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(rx_valid, 2) && $past(rx_native, 2) && !$past(cfg_own_write_en)) |-> !mem_wr_en);

  assert_push_with_write_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_pending) |-> mem_wr_en);

  assert_ovf_cause_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_overflow) |-> ($past(lvl_cnt) == CNT_W'(FIFO_DEPTH)));

  assert_level_bound_R3: assert property (@(posedge clk) disable iff (rst)
    lvl_cnt <= CNT_W'(FIFO_DEPTH));

  assert_tx_tag_R7: assert property (@(posedge clk) disable iff (rst)
    tx_irq |-> tx_valid);

  assert_pending_level_R8: assert property (@(posedge clk) disable iff (rst)
    irq_pending == (lvl_cnt != '0));
endmodule

bind netirq_qualifier netirq_qualifier_chk #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_native(rx_native),
  .cfg_own_write_en(cfg_own_write_en), .mem_wr_en(mem_wr_en),
  .tx_valid(tx_valid), .tx_irq(tx_irq), .irq_pending(irq_pending),
  .irq_overflow(irq_overflow), .lvl_cnt(lvl_cnt)
);

// File: tb/netirq_qualifier_tb.sv
module netirq_qualifier_tb_top;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst;
  logic cfg_match_en, cfg_net_irq_en, cfg_own_write_en, cfg_own_irq_en, cfg_force_all;
  logic aux_wr_en;
  logic [AW-1:0] aux_wr_addr;
  logic [1:0] aux_wr_bits;
  logic rx_valid, rx_irq_flag, rx_native;
  logic [AW-1:0] rx_addr;
  logic [DW-1:0] rx_data;
  logic hw_valid;
  logic [AW-1:0] hw_addr;
  logic [DW-1:0] hw_data;
  logic mem_wr_en, tx_valid, tx_irq, irq_pop, irq_pending, irq_ovf_clear, irq_overflow;
  logic [AW-1:0] mem_wr_addr, tx_addr, irq_head;
  logic [DW-1:0] mem_wr_data, tx_data;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [1:0] m_aux [1 << AW];
  logic [AW-1:0] m_q[$];
  bit m_ovf = 0;

  always #4 clk = ~clk;

  netirq_qualifier #(.ADDR_W(AW), .DATA_W(DW), .FIFO_DEPTH(DEPTH)) dut_i (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit m_write(input bit native);
    return !native || cfg_own_write_en;
  endfunction

  function automatic bit m_push(input bit native, input bit flag, input logic [1:0] a);
    bit q;
    q = cfg_match_en && (cfg_force_all || (flag && a[0]));
    return m_write(native) && q && (!native || cfg_own_irq_en);
  endfunction

  task automatic set_aux(input logic [AW-1:0] a, input logic [1:0] b);
    aux_wr_en = 1; aux_wr_addr = a; aux_wr_bits = b;
    @(negedge clk);
    aux_wr_en = 0;
    m_aux[a] = b;
  endtask

  task automatic check_fifo(input string req);
    chk(req, irq_pending, m_q.size() != 0);
    if (m_q.size() != 0) chk(req, irq_head, m_q[0]);
    chk(req, irq_overflow, m_ovf);
  endtask

  // Send one message; outputs checked after the second rising edge (R9).
  task automatic send(input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input bit flag, input bit native, input string req);
    bit w, p;
    w = m_write(native);
    p = m_push(native, flag, m_aux[a]);
    rx_valid = 1; rx_addr = a; rx_data = d; rx_irq_flag = flag; rx_native = native;
    @(negedge clk);
    rx_valid = 0;
    chk({req, "/R9 early"}, mem_wr_en, 0);
    @(negedge clk);
    chk(req, mem_wr_en, w);
    if (w) begin
      chk(req, mem_wr_addr, a);
      chk(req, mem_wr_data, d);
    end
    if (p) begin
      if (m_q.size() < DEPTH) m_q.push_back(a);
      else m_ovf = 1;
    end
    check_fifo(req);
    @(negedge clk);
    chk({req, "/R9 pulse"}, mem_wr_en, 0);
  endtask

  task automatic pop_one(input string req);
    irq_pop = 1;
    @(negedge clk);
    irq_pop = 0;
    if (m_q.size() != 0) void'(m_q.pop_front());
    check_fifo(req);
  endtask

  task automatic host_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    hw_valid = 1; hw_addr = a; hw_data = d;
    @(negedge clk);
    hw_valid = 0;
    chk("R7 early", tx_valid, 0);
    @(negedge clk);
    chk("R7 valid", tx_valid, 1);
    chk("R7 addr", tx_addr, a);
    chk("R7 data", tx_data, d);
    chk("R7 tag", tx_irq, cfg_net_irq_en && m_aux[a][1]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1;
    {cfg_match_en, cfg_net_irq_en, cfg_own_write_en, cfg_own_irq_en, cfg_force_all} = '0;
    aux_wr_en = 0; aux_wr_addr = '0; aux_wr_bits = '0;
    rx_valid = 0; rx_addr = '0; rx_data = '0; rx_irq_flag = 0; rx_native = 0;
    hw_valid = 0; hw_addr = '0; hw_data = '0; irq_pop = 0; irq_ovf_clear = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R11 mem_wr_en", mem_wr_en, 0);
    chk("R11 tx_valid", tx_valid, 0);
    chk("R11 irq_pending", irq_pending, 0);
    chk("R11 irq_overflow", irq_overflow, 0);

    for (int i = 0; i < (1 << AW); i++) set_aux(AW'(i), 2'(i % 4));

    // R1 / R2 selected mode
    cfg_match_en = 1;
    send(AW'(5), 32'hA5, 1, 0, "R1 qualify");
    send(AW'(4), 32'hA4, 1, 0, "R2 rx bit clear");
    send(AW'(9), 32'hA9, 0, 0, "R2 flag clear");
    cfg_match_en = 0;
    send(AW'(13), 32'hAD, 1, 0, "R2 match clear");
    cfg_match_en = 1;
    pop_one("R8 pop");
    pop_one("R8 pop empty");

    // R4 / R5 native
    send(AW'(17), 32'h11, 1, 1, "R4 native discard");
    cfg_own_write_en = 1;
    send(AW'(17), 32'h12, 1, 1, "R5 own irq off");
    cfg_own_irq_en = 1;
    send(AW'(21), 32'h13, 1, 1, "R5 self irq");
    pop_one("R8 pop self");

    // R6 forced
    cfg_force_all = 1;
    send(AW'(8), 32'h66, 0, 0, "R6 forced");
    cfg_match_en = 0;
    send(AW'(12), 32'h67, 0, 0, "R6 forced match off");
    cfg_match_en = 1; cfg_force_all = 0;
    pop_one("R8 pop forced");

    // R10 same-edge table write sees old bits
    set_aux(AW'(100), 2'b00);
    aux_wr_en = 1; aux_wr_addr = AW'(100); aux_wr_bits = 2'b01;
    rx_valid = 1; rx_addr = AW'(100); rx_data = 32'hCC; rx_irq_flag = 1; rx_native = 0;
    @(negedge clk);
    aux_wr_en = 0; rx_valid = 0;
    @(negedge clk);
    chk("R10 old bits write", mem_wr_en, 1);
    chk("R10 old bits no push", irq_pending, 0);
    m_aux[100] = 2'b01;
    send(AW'(100), 32'hCD, 1, 0, "R10 new bits");
    pop_one("R8 pop R10");

    // R3 overflow
    for (int i = 0; i < DEPTH + 2; i++) send(AW'(4 * i + 1), DW'(i), 1, 0, "R3 fill");
    chk("R3 ovf set", irq_overflow, 1);
    for (int i = 0; i < 3; i++) pop_one("R3 order after drop");
    irq_ovf_clear = 1;
    @(negedge clk);
    irq_ovf_clear = 0; m_ovf = 0;
    chk("R3 ovf cleared", irq_overflow, 0);
    while (m_q.size() != 0) pop_one("R8 drain");

    // R7 transmit tagging
    host_wr(AW'(2), 32'h22);
    cfg_net_irq_en = 1;
    host_wr(AW'(2), 32'h23);
    host_wr(AW'(3), 32'h24);
    host_wr(AW'(1), 32'h25);

    // random mix
    for (int i = 0; i < 300; i++) begin
      cfg_match_en = $urandom_range(0, 3) != 0;
      cfg_own_write_en = $urandom_range(0, 1);
      cfg_own_irq_en = $urandom_range(0, 1);
      cfg_force_all = $urandom_range(0, 4) == 0;
      cfg_net_irq_en = $urandom_range(0, 1);
      case ($urandom_range(0, 4))
        0: set_aux(AW'($urandom_range(0, 63)), 2'($urandom_range(0, 3)));
        1: pop_one("R8 random pop");
        2: host_wr(AW'($urandom_range(0, 63)), $urandom);
        default: send(AW'($urandom_range(0, 63)), $urandom, $urandom_range(0, 1),
                      $urandom_range(0, 3) == 0, "R1 R5 R6 random");
      endcase
      if (m_ovf && $urandom_range(0, 3) == 0) begin
        irq_ovf_clear = 1;
        @(negedge clk);
        irq_ovf_clear = 0; m_ovf = 0;
        chk("R3 random clear", irq_overflow, 0);
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule